// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves data in both directions between two buses, A and B, each `WIDTH` bits wide (18 by default). Every bit has one storage cell per direction. The cell combines a level-sensitive latch and an edge-triggered register. A per-direction pass control selects between them, so each direction can run in one of three ways: pass-through, frozen, or clocked capture. The two directions share no control. Each has its own pass control, strobe and drive enable.

The ports are modelled without tri-state pins. Each bus has a separate input vector, output vector and drive-enable output. A per-bit valid flag on each input stands in for an undriven (floating) wire. When the `BUS_HOLD` parameter is set, a hold register keeps the last validly driven value of each bit. That value replaces the input while the bit's valid flag is low. All sequential elements run on the system clock `clk`. Each direction's strobe is sampled on that clock, and its rising edge is detected there.

Each direction has a four-state controller. The state records the pass control and the strobe level seen at the last clock edge:

- `ST_OPEN_LO`: pass high, strobe low.
- `ST_OPEN_HI`: pass high, strobe high.
- `ST_SHUT_LO`: pass low, strobe low.
- `ST_SHUT_HI`: pass low, strobe high.

The transitions are named as follows:

- **open**: into either OPEN state, because the pass control is high.
- **shut**: into either SHUT state, because the pass control is low.
- **arm**: into a `_LO` state, because the strobe is low.
- **fire**: from `ST_OPEN_LO` or `ST_SHUT_LO` into `ST_SHUT_HI`, with the pass control low and the strobe high. This is the only transition that captures data while the pass control is low.
- **idle**: from a `_HI` state into `ST_SHUT_HI`, with the pass control low and the strobe still high. This transition captures nothing.

Top module: `ubus_xcvr`

## Requirements
- R1: While `ab_pass` is high, `b_out` equals the effective A input in the same cycle, with no clock edge needed. Likewise, while `ba_pass` is high, `a_out` equals the effective B input.
- R2: While `ab_pass` is low and `ab_strobe` shows no rising edge (it stays low or stays high), the stored A-to-B value does not change and `b_out` ignores `a_in`.
- R3: With `ab_pass` low, the first `clk` edge at which `ab_strobe` is high after it was low at the previous edge captures the effective A input. `b_out` shows that value after the edge.
- R4: When `ab_pass` falls, the value held is the effective input at the last `clk` edge at which `ab_pass` was still high.
- R5: `b_drv` follows `ab_drive` and `a_drv` follows `ba_drive`, in the same cycle. Both are active high.
- R6: The B-to-A direction obeys R1 to R4 with `ba_pass`, `ba_strobe` and `b_in`. The controls of one direction never change the other direction's output.
- R7: With `BUS_HOLD` set, a bit whose valid flag is low takes the value that bit had at the last `clk` edge at which its flag was high. This is zero if no such edge has occurred since reset. A bit whose flag is high uses the live input.
- R8: A synchronous reset clears both stored values and both hold registers to zero.
- R9: A rising strobe edge while the pass control is high has no extra effect. If the strobe then stays high after the pass control falls, no capture occurs.
- R10: When both drive enables are high, both `a_drv` and `b_drv` are high at once, with no arbitration between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data arriving on bus A |
| a_vld | input | WIDTH | Per-bit flag: bus A bit is actively driven |
| a_out | output | WIDTH | Data to drive onto bus A (B-to-A path) |
| a_drv | output | 1 | Bus A drive enable |
| b_in | input | WIDTH | Data arriving on bus B |
| b_vld | input | WIDTH | Per-bit flag: bus B bit is actively driven |
| b_out | output | WIDTH | Data to drive onto bus B (A-to-B path) |
| b_drv | output | 1 | Bus B drive enable |
| ab_pass | input | 1 | A-to-B pass-through control |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_drive | input | 1 | A-to-B output enable |
| ba_pass | input | 1 | B-to-A pass-through control |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_drive | input | 1 | B-to-A output enable |

## Verification
The directed scenarios below each target one way the design could go wrong:

- **Strobe held high.** The bench holds a strobe high across many edges with the pass control low. A design that captures on level instead of on the rising edge would let `b_out` drift with `a_in`.
- **Strobe rising while passing.** The bench raises a strobe while the pass control is high, then drops the pass control. A design that remembers that edge would capture again once the pass control falls.
- **Valid flags.** The bench drops valid flags, first all of them and then only part of them. A design with the hold register missing, or with wrong bit selection, would show the junk input or zeros instead of the last valid value.
- **Reset.** The bench resets in the middle of a run and then passes invalid inputs. A design that forgets to clear the hold registers would leak old data.

// File: rtl/ubus_xcvr_pkg.sv
package ubus_xcvr_pkg;

    // Controller state: {pass control, strobe level} seen at the last clk edge
    typedef enum logic [1:0] {
        ST_SHUT_LO = 2'b00,
        ST_SHUT_HI = 2'b01,
        ST_OPEN_LO = 2'b10,
        ST_OPEN_HI = 2'b11
    } path_state_t;

    function automatic path_state_t state_of(input logic pass, input logic strobe);
        path_state_t s;
        unique case ({pass, strobe})
            2'b00:   s = ST_SHUT_LO;
            2'b01:   s = ST_SHUT_HI;
            2'b10:   s = ST_OPEN_LO;
            default: s = ST_OPEN_HI;
        endcase
        return s;
    endfunction

    function automatic logic strobe_was_low(input path_state_t s);
        return (s == ST_SHUT_LO) || (s == ST_OPEN_LO);
    endfunction

endpackage

// File: rtl/ubus_bus_hold.sv
module ubus_bus_hold #(
    parameter int WIDTH  = 18,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] vld,
    output logic [WIDTH-1:0] dout
);

    generate
        if (ENABLE) begin : g_hold
            logic [WIDTH-1:0] last_q;

            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                always_ff @(posedge clk) begin
                    if (rst) begin
                        last_q[i] <= 1'b0;
                    end else if (vld[i]) begin
                        last_q[i] <= din[i];
                    end
                end

                always_comb begin
                    dout[i] = vld[i] ? din[i] : last_q[i];
                end
            end
        end else begin : g_pass
            // Without bus hold an undriven bit is taken at face value
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst, vld};
            assign dout      = din;
        end
    endgenerate

endmodule

// File: rtl/ubus_path.sv
module ubus_path
    import ubus_xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pass,
    input  logic             strobe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    path_state_t      state_q;
    path_state_t      state_d;
    logic             fire;
    logic [WIDTH-1:0] store_q;

    // Next state and capture decision
    always_comb begin
        state_d = state_of(pass, strobe);
        fire    = 1'b0;
        unique case (state_q)
            ST_SHUT_LO, ST_OPEN_LO: fire = !pass && strobe;
            ST_SHUT_HI, ST_OPEN_HI: fire = 1'b0;
            default:                fire = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= state_of(pass, strobe);
        end else begin
            state_q <= state_d;
        end
    end

    // Storage cell: latch while open, register on fire
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (pass || fire) begin
            store_q <= din;
        end
    end

    // Outputs: transparent while open, stored value otherwise
    always_comb begin
        unique case (state_d)
            ST_OPEN_LO, ST_OPEN_HI: dout = din;
            ST_SHUT_LO, ST_SHUT_HI: dout = store_q;
            default:                dout = store_q;
        endcase
    end

endmodule

// File: rtl/ubus_xcvr.sv
module ubus_xcvr #(
    parameter int WIDTH    = 18,
    parameter bit BUS_HOLD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] a_vld,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] b_vld,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv,
    input  logic             ab_pass,
    input  logic             ab_strobe,
    input  logic             ab_drive,
    input  logic             ba_pass,
    input  logic             ba_strobe,
    input  logic             ba_drive
);

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;

    ubus_bus_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_a (
        .clk (clk),
        .rst (rst),
        .din (a_in),
        .vld (a_vld),
        .dout(a_eff)
    );

    ubus_bus_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_b (
        .clk (clk),
        .rst (rst),
        .din (b_in),
        .vld (b_vld),
        .dout(b_eff)
    );

    ubus_path #(.WIDTH(WIDTH)) u_path_ab (
        .clk   (clk),
        .rst   (rst),
        .pass  (ab_pass),
        .strobe(ab_strobe),
        .din   (a_eff),
        .dout  (b_out)
    );

    ubus_path #(.WIDTH(WIDTH)) u_path_ba (
        .clk   (clk),
        .rst   (rst),
        .pass  (ba_pass),
        .strobe(ba_strobe),
        .din   (b_eff),
        .dout  (a_out)
    );

    assign b_drv = ab_drive;
    assign a_drv = ba_drive;

endmodule

// File: rtl/ubus_xcvr_chk.sv
module ubus_xcvr_chk #(
    parameter int WIDTH    = 18,
    parameter bit BUS_HOLD = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_vld,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drv,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_vld,
    input logic [WIDTH-1:0] b_out,
    input logic             b_drv,
    input logic             ab_pass,
    input logic             ab_strobe,
    input logic             ab_drive,
    input logic             ba_pass,
    input logic             ba_strobe,
    input logic             ba_drive
);

    logic ab_stb_q;
    logic ba_stb_q;

    always_ff @(posedge clk) begin
        ab_stb_q <= ab_strobe;
        ba_stb_q <= ba_strobe;
    end

    p_pass_ab_r1: assert property (@(posedge clk) disable iff (rst)
        (ab_pass && &a_vld) |-> (b_out == a_in));

    p_pass_ba_r6: assert property (@(posedge clk) disable iff (rst)
        (ba_pass && &b_vld) |-> (a_out == b_in));

    p_hold_ab_r2: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && !$past(rst) && $past(!ab_pass && !(ab_strobe && !ab_stb_q)))
        |-> (b_out == $past(b_out)));

    p_capture_ab_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && !$past(rst) && $past(!ab_pass && ab_strobe && !ab_stb_q && &a_vld))
        |-> (b_out == $past(a_in)));

    p_capture_ba_r6: assert property (@(posedge clk) disable iff (rst)
        (!ba_pass && !$past(rst) && $past(!ba_pass && ba_strobe && !ba_stb_q && &b_vld))
        |-> (a_out == $past(b_in)));

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((ab_pass || b_out == '0) && (ba_pass || a_out == '0)));

    p_both_drive_r10: assert property (@(posedge clk) disable iff (rst)
        (ab_drive && ba_drive) |-> (a_drv && b_drv));

    generate
        if (BUS_HOLD) begin : g_hold_chk
            p_bus_hold_r7: assert property (@(posedge clk) disable iff (rst)
                (ab_pass && !a_vld[0] && $past(a_vld[0]) && !$past(rst))
                |-> (b_out[0] == $past(a_in[0])));
        end
    endgenerate

endmodule

bind ubus_xcvr ubus_xcvr_chk #(.WIDTH(WIDTH), .BUS_HOLD(BUS_HOLD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .a_vld    (a_vld),
    .a_out    (a_out),
    .a_drv    (a_drv),
    .b_in     (b_in),
    .b_vld    (b_vld),
    .b_out    (b_out),
    .b_drv    (b_drv),
    .ab_pass  (ab_pass),
    .ab_strobe(ab_strobe),
    .ab_drive (ab_drive),
    .ba_pass  (ba_pass),
    .ba_strobe(ba_strobe),
    .ba_drive (ba_drive)
);

// File: tb/test_ubus_xcvr.sv
module test_ubus_xcvr;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, a_vld, a_out, b_in, b_vld, b_out;
    logic         a_drv, b_drv;
    logic         ab_pass, ab_strobe, ab_drive, ba_pass, ba_strobe, ba_drive;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ubus_xcvr #(.WIDTH(W), .BUS_HOLD(1'b1)) i_ubus_xcvr (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_vld(a_vld), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_vld(b_vld), .b_out(b_out), .b_drv(b_drv),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive(ba_drive)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R8 b_out after reset", b_out, '0);
        chk("R8 a_out after reset", a_out, '0);
        chk("R5 b_drv follows ab_drive", {17'd0, b_drv}, 18'd1);
        chk("R5 a_drv follows ba_drive", {17'd0, a_drv}, 18'd1);
    endtask

    task automatic t_transparent;
        ab_pass = 1'b1;
        a_in = 18'h2A5C3; #1;
        chk("R1 transparent first", b_out, 18'h2A5C3);
        a_in = 18'h15A3C; #1;
        chk("R1 transparent same cycle", b_out, 18'h15A3C);
        tick();
        a_in = 18'h3FFFF; #1;
        chk("R1 transparent after edge", b_out, 18'h3FFFF);
    endtask

    task automatic t_latch_fall;
        a_in = 18'h12345; tick();
        ab_pass = 1'b0; a_in = 18'h0BEEF; #1;
        chk("R4 hold value at pass fall", b_out, 18'h12345);
        tick(3);
        chk("R4 R2 still held", b_out, 18'h12345);
    endtask

    task automatic t_capture;
        a_in = 18'h2C0DE; tick();
        chk("R2 strobe low ignores input", b_out, 18'h12345);
        ab_strobe = 1'b1; #1;
        chk("R3 no capture before clk edge", b_out, 18'h12345);
        tick();
        chk("R3 captured on rising strobe", b_out, 18'h2C0DE);
        a_in = 18'h00F0F; tick(4);
        chk("R2 strobe static high ignores input", b_out, 18'h2C0DE);
        ab_strobe = 1'b0; tick(2);
        chk("R2 strobe fall no capture", b_out, 18'h2C0DE);
    endtask

    task automatic t_strobe_in_pass;
        ab_pass = 1'b1; a_in = 18'h11111; tick();
        ab_strobe = 1'b1; a_in = 18'h22222; tick();
        chk("R9 strobe rise while passing", b_out, 18'h22222);
        ab_pass = 1'b0; a_in = 18'h33333; tick(3);
        chk("R9 no capture after pass falls with strobe high", b_out, 18'h22222);
        ab_strobe = 1'b0; tick();
    endtask

    task automatic t_disable;
        ab_drive = 1'b0; #1;
        chk("R5 b_drv released", {17'd0, b_drv}, 18'd0);
        chk("R5 a_drv unaffected", {17'd0, a_drv}, 18'd1);
        ba_drive = 1'b0; #1;
        chk("R5 a_drv released", {17'd0, a_drv}, 18'd0);
        ab_drive = 1'b1; ba_drive = 1'b1; #1;
        chk("R10 both ports driven", {16'd0, a_drv, b_drv}, 18'd3);
    endtask

    task automatic t_independent;
        ba_pass = 1'b1; b_in = 18'h0A0A0; #1;
        chk("R6 ba transparent", a_out, 18'h0A0A0);
        chk("R6 ab output untouched", b_out, 18'h22222);
        tick();
        ba_pass = 1'b0; b_in = 18'h30303; tick();
        chk("R6 ba hold at pass fall", a_out, 18'h0A0A0);
        ba_strobe = 1'b1; tick();
        chk("R6 ba capture", a_out, 18'h30303);
        chk("R6 ab unchanged by ba capture", b_out, 18'h22222);
        ab_pass = 1'b1; a_in = 18'h1CAFE; #1;
        chk("R6 ba unchanged by ab pass", a_out, 18'h30303);
        tick();
        ab_pass = 1'b0; ba_strobe = 1'b0; tick();
    endtask

    task automatic t_bus_hold;
        logic [W-1:0] mask;
        logic [W-1:0] mix;
        mask = 18'h0FF00;
        ab_pass = 1'b1; a_in = 18'h2468A; tick();
        a_vld = '0; a_in = 18'h3D3D3; #1;
        chk("R7 all bits floating use last valid", b_out, 18'h2468A);
        a_vld = mask; a_in = 18'h15555; #1;
        mix = (18'h15555 & mask) | (18'h2468A & ~mask);
        chk("R7 partial valid mask", b_out, mix);
        tick();
        a_vld = '0; a_in = 18'h00000; #1;
        chk("R7 hold updated only on valid bits", b_out, mix);
        tick();
        ab_pass = 1'b0; tick();
        ab_strobe = 1'b1; a_in = 18'h3FFFF; tick();
        chk("R7 R3 capture of held value", b_out, mix);
        ab_strobe = 1'b0; a_vld = '1; tick();
    endtask

    task automatic t_mid_reset;
        rst = 1'b1; tick(); rst = 1'b0; #1;
        chk("R8 b_out cleared mid-run", b_out, '0);
        chk("R8 a_out cleared mid-run", a_out, '0);
        ab_pass = 1'b1; a_vld = '0; a_in = 18'h3ABCD; #1;
        chk("R8 R7 hold register cleared", b_out, '0);
        ab_pass = 1'b0; a_vld = '1; tick();
    endtask

    initial begin
        rst = 1'b1;
        a_in = '0; a_vld = '1; b_in = '0; b_vld = '1;
        ab_pass = 1'b0; ab_strobe = 1'b0; ab_drive = 1'b1;
        ba_pass = 1'b0; ba_strobe = 1'b0; ba_drive = 1'b1;
        tick(4);
        rst = 1'b0;
        tick();
        t_reset();
        t_transparent();
        t_latch_fall();
        t_capture();
        t_strobe_in_pass();
        t_disable();
        t_independent();
        t_bus_hold();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule